// File: doc/BRIEF.md
# Secondary Core Boot Release Controller

This block keeps up to three secondary processor cores parked after power-up. Each core stays parked until software has given it a start address, set its enable bit and then sent a wake event. A small 32-bit register port lets software write the per-core start addresses and the enable mask. The same port reads back a core-count field that comes from a strap input.

Each secondary core has two outputs: a release line and a start-address bus. The release line goes high only on a wake event that arrives after the core's enable bit went from 0 to 1. At that moment the start address is copied from the core's own register and frozen, so later register writes cannot change what the core fetches. Clearing an enable bit parks its core again. Enable bits for cores that the strap marks as absent cannot be set.

Top module: `core_release_ctrl`

## Requirements
- R1: After reset all release outputs are 0 and all start-address outputs are 0. The control word (offset 0) reads 1 and every start-address register reads 0.
- R2: The control word at offset 0 always reads bit 0 as 1, whatever value was written. Bit n (n = 1..3) reads the enable of secondary core n. Bits above 3 read 0.
- R3: The start-address registers of secondary cores 1, 2 and 3 sit at byte offsets 4, 8 and 12. Each is a full 32-bit read/write register.
- R4: Offset 16 reads the strap `core_cnt_m1_i` (number of cores present minus one) in bits [1:0] and 0 above. Writes to offset 16 change nothing.
- R5: Setting an enable bit never releases a core by itself. A core is released on the clock edge that samples `wake_evt_i` high, but only if its enable went from 0 to 1 on an earlier edge. A wake sampled on the same edge as the enabling write does not release it.
- R6: When a core is released, its start-address output equals the value its own register held at the releasing edge.
- R7: While a core stays released, its start-address output does not change, even when its register is rewritten.
- R8: A release stays asserted across idle cycles and later wake events. It drops on the edge that writes the core's enable bit to 0, or on reset. Enabling the core again requires a new wake event before it is released.
- R9: A wake event has no effect on a core that is not enabled, or that was already released.
- R10: Secondary core n is present only when n <= `core_cnt_m1_i`. A write to the enable bit of an absent core is ignored: the bit reads 0 and the core is never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_ofs_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, 0 when not reading |
| core_cnt_m1_i | input | 2 | Number of cores present minus one (static strap) |
| wake_evt_i | input | 1 | Wake event, sampled on each clock edge |
| core_release_o | output | 3 | Bit n-1 releases secondary core n |
| boot_addr_o | output | 96 | Start address of core n in bits [32n-1 : 32(n-1)] |

## Verification
Suppose a core's pending flag is wrong. A core enabled but not armed stays parked after the next wake. A flag left set from an earlier round releases the core without any wake. Both show on `core_release_o` one edge after the wake or the write. A capture register that reloads or samples at the wrong moment shows on `boot_addr_o` on the edge after the rewrite of the address register. A bad present-core mask shows on the very next control-word read. The sweep covers every strap value and every enable mask, so each of these faults is exposed within a few cycles of the stimulus that triggers it.

// File: rtl/crc_pkg.sv
package crc_pkg;
    // word index of the control word and first address register
    localparam int CTRL_WORD  = 0;
    localparam int ADDR_WORD0 = 1;
    localparam int BYTES_PER_WORD = 4;

    function automatic int word_ofs(input int word);
        return word * BYTES_PER_WORD;
    endfunction
endpackage

// File: rtl/crc_regs.sv
module crc_regs
    import crc_pkg::*;
#(
    parameter int NUM_SEC = 3,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int OFS_W   = 5,
    parameter int CNT_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_i,
    input  logic                      we_i,
    input  logic [OFS_W-1:0]          ofs_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic [DATA_W-1:0]         rdata_o,
    input  logic [CNT_W-1:0]          cnt_m1_i,
    output logic [NUM_SEC-1:0]        en_o,
    output logic [NUM_SEC-1:0]        en_set_o,
    output logic [NUM_SEC-1:0]        en_clr_o,
    output logic [NUM_SEC*ADDR_W-1:0] addr_flat_o
);
    localparam int CFG_WORD = ADDR_WORD0 + NUM_SEC;

    typedef struct packed {
        logic [NUM_SEC-1:0]             en;
        logic [NUM_SEC-1:0][ADDR_W-1:0] addr;
    } regs_t;

    regs_t              st_d, st_q;
    logic [NUM_SEC-1:0] present;
    logic               wr, rd;

    always_comb begin
        st_d    = st_q;
        rdata_o = '0;
        wr      = sel_i && we_i;
        rd      = sel_i && !we_i;
        for (int i = 0; i < NUM_SEC; i++) begin
            present[i] = (i < int'(cnt_m1_i));
        end
        if (wr && ofs_i == OFS_W'(word_ofs(CTRL_WORD))) begin
            st_d.en = wdata_i[NUM_SEC:1] & present;
        end
        for (int k = 0; k < NUM_SEC; k++) begin
            if (wr && ofs_i == OFS_W'(word_ofs(ADDR_WORD0 + k))) begin
                st_d.addr[k] = wdata_i[ADDR_W-1:0];
            end
            if (rd && ofs_i == OFS_W'(word_ofs(ADDR_WORD0 + k))) begin
                rdata_o[ADDR_W-1:0] = st_q.addr[k];
            end
        end
        if (rd && ofs_i == OFS_W'(word_ofs(CTRL_WORD))) begin
            rdata_o[0]         = 1'b1;
            rdata_o[NUM_SEC:1] = st_q.en;
        end
        if (rd && ofs_i == OFS_W'(word_ofs(CFG_WORD))) begin
            rdata_o[CNT_W-1:0] = cnt_m1_i;
        end
        en_set_o = st_d.en & ~st_q.en;
        en_clr_o = st_q.en & ~st_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o        = st_q.en;
    assign addr_flat_o = st_q.addr;
endmodule

// File: rtl/crc_slot.sv
module crc_slot #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              wake_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              rel_o,
    output logic [ADDR_W-1:0] boot_o
);
    typedef struct packed {
        logic              pend;
        logic              rel;
        logic [ADDR_W-1:0] boot;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wake_i && st_q.pend) begin
            st_d.pend = 1'b0;
            st_d.rel  = 1'b1;
            st_d.boot = addr_i;
        end
        if (en_set_i) begin
            st_d.pend = 1'b1;
        end
        if (en_clr_i) begin
            st_d.pend = 1'b0;
            st_d.rel  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rel_o  = st_q.rel;
    assign boot_o = st_q.boot;
endmodule

// File: rtl/core_release_ctrl.sv
module core_release_ctrl #(
    parameter int NUM_SEC = 3,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int OFS_W   = 5,
    parameter int CNT_W   = $clog2(NUM_SEC + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel_i,
    input  logic                      bus_we_i,
    input  logic [OFS_W-1:0]          bus_ofs_i,
    input  logic [DATA_W-1:0]         bus_wdata_i,
    output logic [DATA_W-1:0]         bus_rdata_o,
    input  logic [CNT_W-1:0]          core_cnt_m1_i,
    input  logic                      wake_evt_i,
    output logic [NUM_SEC-1:0]        core_release_o,
    output logic [NUM_SEC*ADDR_W-1:0] boot_addr_o
);
    logic [NUM_SEC-1:0]        en_vec, en_set, en_clr;
    logic [NUM_SEC*ADDR_W-1:0] addr_flat;

    crc_regs #(
        .NUM_SEC(NUM_SEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OFS_W(OFS_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sel_i(bus_sel_i), .we_i(bus_we_i), .ofs_i(bus_ofs_i),
        .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
        .cnt_m1_i(core_cnt_m1_i),
        .en_o(en_vec), .en_set_o(en_set), .en_clr_o(en_clr),
        .addr_flat_o(addr_flat)
    );

    for (genvar i = 0; i < NUM_SEC; i++) begin : g_slot
        crc_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .en_set_i(en_set[i]), .en_clr_i(en_clr[i]),
            .wake_i(wake_evt_i),
            .addr_i(addr_flat[i*ADDR_W +: ADDR_W]),
            .rel_o(core_release_o[i]),
            .boot_o(boot_addr_o[i*ADDR_W +: ADDR_W])
        );
    end
endmodule

// File: rtl/crc_checker.sv
module crc_checker #(
    parameter int NUM_SEC = 3,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int OFS_W   = 5,
    parameter int CNT_W   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_sel_i,
    input logic                      bus_we_i,
    input logic [OFS_W-1:0]          bus_ofs_i,
    input logic [DATA_W-1:0]         bus_rdata_o,
    input logic [CNT_W-1:0]          core_cnt_m1_i,
    input logic                      wake_evt_i,
    input logic [NUM_SEC-1:0]        core_release_o,
    input logic [NUM_SEC*ADDR_W-1:0] boot_addr_o,
    input logic [NUM_SEC-1:0]        en_vec,
    input logic [NUM_SEC*ADDR_W-1:0] addr_flat
);
    localparam int CFG_OFS = 4 * (NUM_SEC + 1);

    AST_CTRL_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_we_i && bus_ofs_i == '0) |-> bus_rdata_o[0]); // R2

    AST_CFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_we_i && bus_ofs_i == OFS_W'(CFG_OFS))
        |-> bus_rdata_o == DATA_W'(core_cnt_m1_i)); // R4

    AST_REL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_release_o & ~en_vec) == '0); // R8

    for (genvar i = 0; i < NUM_SEC; i++) begin : g_core
        AST_REL_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_release_o[i]) |-> ($past(wake_evt_i) && $past(en_vec[i]))); // R5

        AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_release_o[i])
            |-> boot_addr_o[i*ADDR_W +: ADDR_W] == $past(addr_flat[i*ADDR_W +: ADDR_W])); // R6

        AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (core_release_o[i] && $past(core_release_o[i]))
            |-> $stable(boot_addr_o[i*ADDR_W +: ADDR_W])); // R7

        AST_ABSENT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (i >= int'(core_cnt_m1_i)) |-> !en_vec[i]); // R10
    end
endmodule

bind core_release_ctrl crc_checker #(
    .NUM_SEC(NUM_SEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_W(OFS_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_ofs_i(bus_ofs_i),
    .bus_rdata_o(bus_rdata_o), .core_cnt_m1_i(core_cnt_m1_i),
    .wake_evt_i(wake_evt_i), .core_release_o(core_release_o),
    .boot_addr_o(boot_addr_o), .en_vec(en_vec), .addr_flat(addr_flat)
);

// File: tb/core_release_ctrl_bench.sv
module core_release_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0, wake = 1'b0;
    logic [4:0]  ofs = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  cnt = '0;
    logic [2:0]  rel;
    logic [95:0] boot;
    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    core_release_ctrl u_core_release_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_sel_i(sel), .bus_we_i(we), .bus_ofs_i(ofs),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .core_cnt_m1_i(cnt), .wake_evt_i(wake),
        .core_release_o(rel), .boot_addr_o(boot)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] o, input logic [31:0] d, input logic w);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; ofs = o; wdata = d; wake = w;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wake = 1'b0;
    endtask

    task automatic rd(input logic [4:0] o, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; ofs = o;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    function automatic logic [31:0] addr_of(input int c, input int m, input int k);
        return 32'h8000_0003 | (c << 16) | (m << 8) | (k << 4);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int c = 0; c < 4; c++) begin
            logic [2:0] pm;
            pm = 3'((1 << c) - 1);
            rst_n = 1'b0; cnt = 2'(c);
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            chk("R1 release", 32'(rel), 32'h0);
            chk("R1 boot", 32'(|boot), 32'h0);
            rd(5'd0, v); chk("R1 ctrl", v, 32'h1);
            for (int k = 0; k < 3; k++) begin
                rd(5'(4 + 4*k), v); chk("R1 addr", v, 32'h0);
            end
            rd(5'd16, v); chk("R4 cfg", v, 32'(c));
            wr(5'd16, 32'hFFFF_FFFF, 1'b0);
            rd(5'd16, v); chk("R4 cfg after write", v, 32'(c));
            pulse_wake();
            chk("R9 wake idle", 32'(rel), 32'h0);
            for (int m = 0; m < 8; m++) begin
                logic [2:0] exp_rel;
                exp_rel = 3'(m) & pm;
                for (int k = 0; k < 3; k++) wr(5'(4 + 4*k), addr_of(c, m, k), 1'b0);
                for (int k = 0; k < 3; k++) begin
                    rd(5'(4 + 4*k), v); chk("R3 addr rw", v, addr_of(c, m, k));
                end
                wr(5'd0, 32'(m << 1), 1'b0);
                chk("R5 no release on enable", 32'(rel), 32'h0);
                rd(5'd0, v); chk("R2 R10 ctrl read", v, 32'({exp_rel, 1'b1}));
                pulse_wake();
                chk("R5 release after wake", 32'(rel), 32'(exp_rel));
                for (int k = 0; k < 3; k++)
                    if (exp_rel[k]) chk("R6 boot addr", boot[k*32 +: 32], addr_of(c, m, k));
                for (int k = 0; k < 3; k++) wr(5'(4 + 4*k), ~addr_of(c, m, k), 1'b0);
                for (int k = 0; k < 3; k++)
                    if (exp_rel[k]) chk("R7 boot held", boot[k*32 +: 32], addr_of(c, m, k));
                rd(5'd8, v); chk("R3 addr rewrite", v, ~addr_of(c, m, 1));
                repeat (3) @(negedge clk);
                pulse_wake();
                chk("R8 R9 release held", 32'(rel), 32'(exp_rel));
                wr(5'd0, 32'h0, 1'b0);
                chk("R8 release cleared", 32'(rel), 32'h0);
                wr(5'd0, 32'(m << 1), 1'b1);
                chk("R5 same-edge wake ignored", 32'(rel), 32'h0);
                pulse_wake();
                chk("R5 release on later wake", 32'(rel), 32'(exp_rel));
                for (int k = 0; k < 3; k++)
                    if (exp_rel[k]) chk("R6 new capture", boot[k*32 +: 32], ~addr_of(c, m, k));
                wr(5'd0, 32'h0, 1'b0);
                chk("R8 cleared again", 32'(rel), 32'h0);
            end
        end
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule